// File: doc/BRIEF.md
# Work Tag State Tracker

This block tracks the scheduling tag of each of several processing cores. Every core has a two-bit tag type and a tag value, and it changes them through four command strobes: a tag switch (carrying a target type and a value), a null-switch load, a new work request (carrying the type and value of the incoming work) and a deschedule. The block checks each command against the legal transitions of a four-state tag machine. A command that breaks those rules is refused and reported with a one-cycle error pulse.

Atomic tags are exclusive. No two cores may hold the same value as an atomic tag at the same time. A request for an atomic value that another core already holds waits in a pending state and is granted automatically once the holder lets go. When several requests compete for the same free atomic value, the lowest-numbered core wins. Ordered and null tags may be shared freely.

Top module: `work_tag_tracker`

## Requirements
- R1: After reset every core reports tag type 3 (null-null), value 0, no pending request and no error.
- R2: The tag type encoding is 0 ordered, 1 atomic, 2 null, 3 null-null. A legal switch to ordered or null loads the target type and value, and they appear on the outputs after the next clock edge.
- R3: A deschedule puts the core into null-null after the next edge and cancels any pending request.
- R4: A tag switch whose target is null-null is illegal. So is any tag switch issued while the core is in null-null.
- R5: A tag switch from null to null is illegal.
- R6: A new work request is legal only in null-null with a target other than null-null, and it loads the supplied type and value. A null-switch load is legal only in null-null; it sets the type to null and keeps the value.
- R7: A switch or new work request to atomic value V, while another core holds V as atomic, leaves the requester's state unchanged and raises its pending flag. The request is granted on the edge after the holder's state leaves atomic V.
- R8: When several cores compete for the same free atomic value in one cycle, pending or new, the lowest-numbered core is granted and the rest become (or stay) pending.
- R9: An illegal command leaves the core's type, value and pending flag unchanged and raises that core's error output for exactly one cycle. While a request is pending, every command except deschedule is illegal.
- R10: Any number of cores may hold the same value as an ordered tag.
- R11: When several commands reach one core in the same cycle, only the highest-priority one acts. The order, highest first, is deschedule, new work, null-switch load, switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_switch | input | NCORES | Tag switch strobe, one bit per core |
| cmd_nullload | input | NCORES | Null-switch load strobe, one bit per core |
| cmd_getwork | input | NCORES | New work request strobe, one bit per core |
| cmd_desched | input | NCORES | Deschedule strobe, one bit per core |
| cmd_type | input | 2*NCORES | Target tag type per core, used by switch and new work |
| cmd_value | input | TAGW*NCORES | Target tag value per core, used by switch and new work |
| tag_type | output | 2*NCORES | Current tag type per core |
| tag_value | output | TAGW*NCORES | Current tag value per core |
| pending | output | NCORES | Atomic request waiting, per core |
| err | output | NCORES | One-cycle illegal-command pulse, per core |

## Verification
Four properties are checked on every cycle. No two cores ever hold the same atomic value. A deschedule always lands in null-null with nothing pending. A core outside null-null never drops into it except through a deschedule. An error pulse always coincides with unchanged state. What the per-cycle properties cannot show is left to bench scenarios: that a waiting core is granted exactly one edge after the holder leaves, that contested grants follow core index, that each illegal case is actually refused, and that same-cycle commands resolve by priority. The behavioural model covers these, both in directed sequences and in a long pseudo-random run over a small value set that forces collisions.

// File: rtl/work_tag_tracker.sv
module work_tag_tracker #(
  parameter int NCORES = 4,
  parameter int TAGW   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NCORES-1:0]        cmd_switch,
  input  logic [NCORES-1:0]        cmd_nullload,
  input  logic [NCORES-1:0]        cmd_getwork,
  input  logic [NCORES-1:0]        cmd_desched,
  input  logic [2*NCORES-1:0]      cmd_type,
  input  logic [TAGW*NCORES-1:0]   cmd_value,
  output logic [2*NCORES-1:0]      tag_type,
  output logic [TAGW*NCORES-1:0]   tag_value,
  output logic [NCORES-1:0]        pending,
  output logic [NCORES-1:0]        err
);
  localparam logic [1:0] T_ORD = 2'd0, T_ATM = 2'd1, T_NUL = 2'd2, T_NN = 2'd3;

  logic [1:0]      ty_q   [NCORES];
  logic [TAGW-1:0] val_q  [NCORES];
  logic [TAGW-1:0] pval_q [NCORES];
  logic [NCORES-1:0] pend_q, err_q;

  logic [NCORES-1:0] want, bad, load, grant;
  logic [1:0]        ld_ty  [NCORES];
  logic [TAGW-1:0]   ld_val [NCORES];
  logic [TAGW-1:0]   tgt    [NCORES];

  always_comb begin
    for (int i = 0; i < NCORES; i++) begin
      want[i]   = 1'b0;
      bad[i]    = 1'b0;
      load[i]   = 1'b0;
      ld_ty[i]  = ty_q[i];
      ld_val[i] = val_q[i];
      tgt[i]    = pval_q[i];
      if (cmd_desched[i]) begin
        load[i] = 1'b0;
      end else if (pend_q[i]) begin
        if (cmd_getwork[i] || cmd_nullload[i] || cmd_switch[i]) bad[i] = 1'b1;
        else want[i] = 1'b1;
      end else if (cmd_getwork[i]) begin
        if (ty_q[i] != T_NN || cmd_type[2*i +: 2] == T_NN) bad[i] = 1'b1;
        else if (cmd_type[2*i +: 2] == T_ATM) begin
          want[i] = 1'b1;
          tgt[i]  = cmd_value[TAGW*i +: TAGW];
        end else begin
          load[i]   = 1'b1;
          ld_ty[i]  = cmd_type[2*i +: 2];
          ld_val[i] = cmd_value[TAGW*i +: TAGW];
        end
      end else if (cmd_nullload[i]) begin
        if (ty_q[i] != T_NN) bad[i] = 1'b1;
        else begin
          load[i]  = 1'b1;
          ld_ty[i] = T_NUL;
        end
      end else if (cmd_switch[i]) begin
        if (ty_q[i] == T_NN || cmd_type[2*i +: 2] == T_NN ||
            (ty_q[i] == T_NUL && cmd_type[2*i +: 2] == T_NUL)) bad[i] = 1'b1;
        else if (cmd_type[2*i +: 2] == T_ATM) begin
          want[i] = 1'b1;
          tgt[i]  = cmd_value[TAGW*i +: TAGW];
        end else begin
          load[i]   = 1'b1;
          ld_ty[i]  = cmd_type[2*i +: 2];
          ld_val[i] = cmd_value[TAGW*i +: TAGW];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCORES; i++) begin
      grant[i] = want[i];
      for (int j = 0; j < NCORES; j++) begin
        if (j != i && ty_q[j] == T_ATM && val_q[j] == tgt[i]) grant[i] = 1'b0;
        if (j < i && want[j] && tgt[j] == tgt[i]) grant[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      err_q  <= '0;
      for (int i = 0; i < NCORES; i++) begin
        ty_q[i]   <= T_NN;
        val_q[i]  <= '0;
        pval_q[i] <= '0;
      end
    end else begin
      err_q <= bad;
      for (int i = 0; i < NCORES; i++) begin
        if (cmd_desched[i]) begin
          ty_q[i]   <= T_NN;
          pend_q[i] <= 1'b0;
        end else if (load[i]) begin
          ty_q[i]  <= ld_ty[i];
          val_q[i] <= ld_val[i];
        end else if (want[i]) begin
          if (grant[i]) begin
            ty_q[i]   <= T_ATM;
            val_q[i]  <= tgt[i];
            pend_q[i] <= 1'b0;
          end else begin
            pend_q[i] <= 1'b1;
            pval_q[i] <= tgt[i];
          end
        end
      end
    end
  end

  assign pending = pend_q;
  assign err     = err_q;

  for (genvar g = 0; g < NCORES; g++) begin : g_core
    assign tag_type[2*g +: 2]        = ty_q[g];
    assign tag_value[TAGW*g +: TAGW] = val_q[g];

    AST_DESCHED_TO_NN: assert property (@(posedge clk) disable iff (rst)
      cmd_desched[g] |=> (ty_q[g] == T_NN && !pend_q[g])); // R3
    AST_NO_SILENT_NN: assert property (@(posedge clk) disable iff (rst)
      (ty_q[g] != T_NN && !cmd_desched[g]) |=> (ty_q[g] != T_NN)); // R4
    AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
      err_q[g] |-> (ty_q[g] == $past(ty_q[g]) && val_q[g] == $past(val_q[g]) &&
                    pend_q[g] == $past(pend_q[g]))); // R9

    for (genvar h = g + 1; h < NCORES; h++) begin : g_pair
      AST_ATOMIC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ty_q[g] == T_ATM && ty_q[h] == T_ATM && val_q[g] == val_q[h])); // R7
    end
  end
endmodule

// File: tb/tb_work_tag_tracker.sv
`timescale 1ns/1ps
module tb_work_tag_tracker;
  localparam int N = 4;
  localparam int W = 32;
  localparam int ORD = 0, ATM = 1, NUL = 2, NN = 3;

  logic clk = 0, rst = 1;
  logic [N-1:0] sw = '0, nl = '0, gw = '0, ds = '0;
  logic [2*N-1:0] ctype = '0;
  logic [W*N-1:0] cval = '0;
  logic [2*N-1:0] tag_type;
  logic [W*N-1:0] tag_value;
  logic [N-1:0] pending, err;

  work_tag_tracker #(.NCORES(N), .TAGW(W)) dut (
    .clk(clk), .rst(rst), .cmd_switch(sw), .cmd_nullload(nl), .cmd_getwork(gw),
    .cmd_desched(ds), .cmd_type(ctype), .cmd_value(cval),
    .tag_type(tag_type), .tag_value(tag_value), .pending(pending), .err(err));

  always #10 clk = ~clk;

  int m_ty[N], m_pend[N], m_err[N];
  logic [W-1:0] m_val[N], m_pval[N];
  int vectors = 0, fails = 0;
  string cur_req = "R1";
  logic [31:0] seed = 32'h1234_5678;

  task automatic set_cmd(int c, string kind, int t, logic [W-1:0] v);
    if (kind == "sw") sw[c] = 1'b1;
    if (kind == "nl") nl[c] = 1'b1;
    if (kind == "gw") gw[c] = 1'b1;
    if (kind == "ds") ds[c] = 1'b1;
    ctype[2*c +: 2] = 2'(t);
    cval[W*c +: W] = v;
  endtask

  task automatic model_step();
    int want[N], bad[N], ld[N], lty[N];
    logic [W-1:0] lval[N], tg[N];
    for (int i = 0; i < N; i++) begin
      int t; logic [W-1:0] v;
      t = int'(ctype[2*i +: 2]); v = cval[W*i +: W];
      want[i] = 0; bad[i] = 0; ld[i] = 0; lty[i] = m_ty[i]; lval[i] = m_val[i]; tg[i] = m_pval[i];
      if (ds[i]) ;
      else if (m_pend[i] != 0) begin
        if (gw[i] || nl[i] || sw[i]) bad[i] = 1; else want[i] = 1;
      end else if (gw[i]) begin
        if (m_ty[i] != NN || t == NN) bad[i] = 1;
        else if (t == ATM) begin want[i] = 1; tg[i] = v; end
        else begin ld[i] = 1; lty[i] = t; lval[i] = v; end
      end else if (nl[i]) begin
        if (m_ty[i] != NN) bad[i] = 1; else begin ld[i] = 1; lty[i] = NUL; end
      end else if (sw[i]) begin
        if (m_ty[i] == NN || t == NN || (m_ty[i] == NUL && t == NUL)) bad[i] = 1;
        else if (t == ATM) begin want[i] = 1; tg[i] = v; end
        else begin ld[i] = 1; lty[i] = t; lval[i] = v; end
      end
    end
    begin
      int nty[N], npend[N];
      logic [W-1:0] nval[N], npval[N];
      for (int i = 0; i < N; i++) begin
        nty[i] = m_ty[i]; nval[i] = m_val[i]; npend[i] = m_pend[i]; npval[i] = m_pval[i];
        if (ds[i]) begin nty[i] = NN; npend[i] = 0; end
        else if (ld[i] != 0) begin nty[i] = lty[i]; nval[i] = lval[i]; end
        else if (want[i] != 0) begin
          bit held = 0;
          for (int j = 0; j < N; j++)
            if (j != i && m_ty[j] == ATM && m_val[j] == tg[i]) held = 1;
          for (int j = 0; j < i; j++)
            if (want[j] != 0 && tg[j] == tg[i]) held = 1;
          if (!held) begin nty[i] = ATM; nval[i] = tg[i]; npend[i] = 0; end
          else begin npend[i] = 1; npval[i] = tg[i]; end
        end
      end
      for (int i = 0; i < N; i++) begin
        m_ty[i] = nty[i]; m_val[i] = nval[i]; m_pend[i] = npend[i];
        m_pval[i] = npval[i]; m_err[i] = bad[i];
      end
    end
  endtask

  task automatic compare();
    for (int i = 0; i < N; i++) begin
      vectors++;
      if (int'(tag_type[2*i +: 2]) != m_ty[i] || tag_value[W*i +: W] != m_val[i] ||
          int'(pending[i]) != m_pend[i] || int'(err[i]) != m_err[i]) begin
        fails++;
        $display("FAIL %s core %0d: got type=%0d val=%h pend=%0d err=%0d, expected type=%0d val=%h pend=%0d err=%0d",
                 cur_req, i, tag_type[2*i +: 2], tag_value[W*i +: W], pending[i], err[i],
                 m_ty[i], m_val[i], m_pend[i], m_err[i]);
      end
    end
  endtask

  task automatic expect_core(int c, int ty, int pd, int er, string req);
    vectors++;
    if (int'(tag_type[2*c +: 2]) != ty || int'(pending[c]) != pd || int'(err[c]) != er) begin
      fails++;
      $display("FAIL %s core %0d: got type=%0d pend=%0d err=%0d, expected type=%0d pend=%0d err=%0d",
               req, c, tag_type[2*c +: 2], pending[c], err[c], ty, pd, er);
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    sw = '0; nl = '0; gw = '0; ds = '0;
  endtask

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_ty[i] = NN; m_val[i] = '0; m_pend[i] = 0; m_pval[i] = '0; m_err[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1"; compare();
    for (int i = 0; i < N; i++) expect_core(i, NN, 0, 0, "R1");

    cur_req = "R6"; set_cmd(0, "gw", ORD, 32'h10); tick();
    expect_core(0, ORD, 0, 0, "R6");
    set_cmd(1, "nl", 0, 32'h0); tick();
    expect_core(1, NUL, 0, 0, "R6");
    cur_req = "R9"; set_cmd(1, "nl", 0, 32'h0); tick();
    expect_core(1, NUL, 0, 1, "R9");
    tick();
    expect_core(1, NUL, 0, 0, "R9");

    cur_req = "R5"; set_cmd(1, "sw", NUL, 32'h7); tick();
    expect_core(1, NUL, 0, 1, "R5");
    cur_req = "R4"; set_cmd(2, "sw", ORD, 32'h3); set_cmd(0, "sw", NN, 32'h3); tick();
    expect_core(2, NN, 0, 1, "R4");
    expect_core(0, ORD, 0, 1, "R4");

    cur_req = "R2"; set_cmd(0, "sw", ATM, 32'hA); tick();
    expect_core(0, ATM, 0, 0, "R2");

    cur_req = "R10"; set_cmd(2, "gw", ORD, 32'h55); set_cmd(1, "sw", ORD, 32'h55); tick();
    expect_core(1, ORD, 0, 0, "R10");
    expect_core(2, ORD, 0, 0, "R10");

    cur_req = "R7"; set_cmd(1, "sw", ATM, 32'hA); set_cmd(3, "gw", ATM, 32'hA); tick();
    expect_core(1, ORD, 1, 0, "R7");
    expect_core(3, NN, 1, 0, "R7");
    cur_req = "R9"; set_cmd(1, "sw", ORD, 32'h1); tick();
    expect_core(1, ORD, 1, 1, "R9");
    cur_req = "R7"; set_cmd(0, "sw", ORD, 32'h1); tick();
    expect_core(1, ORD, 1, 0, "R7");
    cur_req = "R8"; tick();
    expect_core(1, ATM, 0, 0, "R8");
    expect_core(3, NN, 1, 0, "R8");
    cur_req = "R3"; set_cmd(1, "ds", 0, 32'h0); tick();
    expect_core(1, NN, 0, 0, "R3");
    cur_req = "R7"; tick();
    expect_core(3, ATM, 0, 0, "R7");

    cur_req = "R8"; set_cmd(0, "sw", ATM, 32'hB); set_cmd(2, "sw", ATM, 32'hB); tick();
    expect_core(0, ATM, 0, 0, "R8");
    expect_core(2, ORD, 1, 0, "R8");
    cur_req = "R3"; set_cmd(2, "ds", 0, 32'h0); tick();
    expect_core(2, NN, 0, 0, "R3");

    cur_req = "R11"; set_cmd(0, "sw", ORD, 32'h9); set_cmd(0, "ds", ORD, 32'h9); tick();
    expect_core(0, NN, 0, 0, "R11");
    set_cmd(1, "nl", ORD, 32'h9); set_cmd(1, "gw", ORD, 32'h9); tick();
    expect_core(1, ORD, 0, 0, "R11");

    cur_req = "R7 R8 random";
    for (int k = 0; k < 600; k++) begin
      for (int c = 0; c < N; c++) begin
        logic [31:0] r;
        r = rnd();
        ctype[2*c +: 2] = r[5:4];
        cval[W*c +: W] = {30'd0, r[7:6]};
        case (r[2:0])
          3'd0, 3'd1: sw[c] = 1'b1;
          3'd2: nl[c] = 1'b1;
          3'd3: gw[c] = 1'b1;
          3'd4: ds[c] = 1'b1;
          default: ;
        endcase
        if (r[12:9] == 4'hF) sw[c] = 1'b1;
      end
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule